// File: doc/BRIEF.md
# Indirect colour palette controller

This block holds the colour lookup table for a display pipeline that works on 8-bit indexed pixels. A host reaches it through three byte-wide ports that share one write strobe and a two-bit port selector. A byte written to the address port sets a shared index. Bytes then written to the palette data port fill the red, green and blue components of the table entry at that index. Bytes written to the control data port load the small control register chosen by the same index.

The table has 256 entries of 24 bits. An entry changes only when its blue byte arrives, so a half-finished load never reaches the screen. The pixel side presents an index on every clock and gets the 24-bit colour one cycle later, in the same clock domain. Two control registers drive outputs: a pixel format code that goes to the serialiser, and a bit that selects which memory bank feeds the display.

Top module: `clut_window`

## Requirements
- R1: After reset the address reads back 0, the component position is red, `fmt_code` is 0x10, `bank_one` is 1, `pix_rgb` is 0, and control registers 0x10 and 0x11 read 0.
- R2: Port select codes are 0 for address, 1 for control data and 2 for palette data. A write with select 0 loads the address, and a read with select 0 returns it.
- R3: Three palette data writes in a row load the entry at the address with red in bits 23:16, green in 15:8 and blue in 7:0. The entry changes on the blue write only, and the address is left unchanged, so a fourth write starts a new red byte for the same entry.
- R4: A write to the address port sets the component position back to red. Red or green bytes already written are discarded, and the entry keeps its old value.
- R5: `pix_rgb` shows the entry at `pix_idx` one clock after `pix_idx` is sampled. If the entry is loaded on that same edge, the old value is returned and the new value is returned from the next edge on.
- R6: A control data write stores the byte in register 0x10, 0x11, 0x20 or 0x21, whichever the address selects. A read with select 1 returns that register.
- R7: `fmt_code` always equals register 0x20, and `bank_one` equals bit 0 of register 0x21 (1 selects bank one, 0 selects bank two).
- R8: A control data write to any other index changes no register, and a read with select 1 at such an index returns 0.
- R9: Loading one entry leaves every other entry unchanged.
- R10: A write with select 3 changes neither the address, nor the component position, nor any register or entry. A read with select 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and pixel sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 2 | Port select: 0 address, 1 control data, 2 palette data, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read data for the selected port (combinational) |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Colour for the index sampled on the previous edge |
| fmt_code | output | 8 | Pixel format code from control register 0x20 |
| bank_one | output | 1 | 1 selects memory bank one, 0 selects bank two |

## Verification
The properties assume that `host_sel` and `host_wr` have known values on every edge after reset, so that each cycle is exactly one of an address write, a control write, a palette write or an idle cycle. The bench meets this by driving every host input on the falling edge, with all four select codes, including the unused one, drawn during the random phase. It also assumes the host may stop a colour load part way through at any time. The stimulus does this on purpose by mixing address writes between palette writes, and it moves `pix_idx` onto entries while they are being loaded.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_CTL  = 2'd1,
    PORT_PAL  = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam int N_CTL = 4;

  localparam logic [7:0] CTL_AUX0 = 8'h10;
  localparam logic [7:0] CTL_AUX1 = 8'h11;
  localparam logic [7:0] CTL_FMT  = 8'h20;
  localparam logic [7:0] CTL_BANK = 8'h21;

  localparam logic [7:0] FMT_RST  = 8'h10;
  localparam logic [7:0] BANK_RST = 8'h01;

  localparam int SLOT_FMT  = 2;
  localparam int SLOT_BANK = 3;

  // Slot in the control file for an index; N_CTL means none.
  function automatic int ctl_slot(input logic [7:0] idx);
    case (idx)
      CTL_AUX0: return 0;
      CTL_AUX1: return 1;
      CTL_FMT:  return SLOT_FMT;
      CTL_BANK: return SLOT_BANK;
      default:  return N_CTL;
    endcase
  endfunction

  function automatic logic ctl_known(input logic [7:0] idx);
    return ctl_slot(idx) != N_CTL;
  endfunction

  function automatic logic [7:0] ctl_reset_val(input int slot);
    case (slot)
      SLOT_FMT:  return FMT_RST;
      SLOT_BANK: return BANK_RST;
      default:   return 8'h00;
    endcase
  endfunction

  // Component position: red(0) -> green(1) -> blue(2) -> red.
  function automatic logic [1:0] next_comp(input logic [1:0] c);
    return (c == 2'd2) ? 2'd0 : c + 2'd1;
  endfunction

endpackage

// File: rtl/clut_host_if.sv
module clut_host_if
  import clut_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int RGB_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CH_W-1:0]  host_wdata,
  output logic [CH_W-1:0]  addr_q,
  output logic [1:0]       comp_q,
  output logic             ctl_wr_evt,
  output logic             commit_evt,
  output logic [RGB_W-1:0] commit_rgb
);

  logic [CH_W-1:0] red_q;
  logic [CH_W-1:0] grn_q;
  logic            addr_wr_evt;
  logic            pal_wr_evt;
  port_e           sel;

  function automatic logic [RGB_W-1:0] pack_rgb(input logic [CH_W-1:0] r,
                                                input logic [CH_W-1:0] g,
                                                input logic [CH_W-1:0] b);
    return {r, g, b};
  endfunction

  always_comb begin
    sel         = port_e'(host_sel);
    addr_wr_evt = host_wr && (sel == PORT_ADDR);
    ctl_wr_evt  = host_wr && (sel == PORT_CTL);
    pal_wr_evt  = host_wr && (sel == PORT_PAL);
    commit_evt  = pal_wr_evt && (comp_q == 2'd2);
    commit_rgb  = pack_rgb(red_q, grn_q, host_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      comp_q <= 2'd0;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (addr_wr_evt) begin
      addr_q <= host_wdata;
      comp_q <= 2'd0;
    end else if (pal_wr_evt) begin
      if (comp_q == 2'd0) red_q <= host_wdata;
      if (comp_q == 2'd1) grn_q <= host_wdata;
      comp_q <= next_comp(comp_q);
    end
  end

endmodule

// File: rtl/clut_ctl_regs.sv
module clut_ctl_regs
  import clut_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] idx,
  input  logic [CH_W-1:0] wdata,
  output logic [CH_W-1:0] rd_data,
  output logic [CH_W-1:0] fmt_q,
  output logic            bank_bit
);

  logic [CH_W-1:0] regs [N_CTL];
  logic [7:0]      idx8;
  int              slot;

  always_comb begin
    idx8 = 8'(idx);
    slot = ctl_slot(idx8);
  end

  for (genvar s = 0; s < N_CTL; s++) begin : g_reg
    logic hit;
    assign hit = wr_en && (slot == s);
    always_ff @(posedge clk) begin
      if (!rst_n) regs[s] <= CH_W'(ctl_reset_val(s));
      else if (hit) regs[s] <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < N_CTL; s++) begin
      if (slot == s) rd_data = regs[s];
    end
  end

  assign fmt_q    = regs[SLOT_FMT];
  assign bank_bit = regs[SLOT_BANK][0];

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int CH_W = 8,
  localparam int RGB_W = 3 * CH_W,
  localparam int DEPTH = 1 << CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic [CH_W-1:0]  raddr,
  output logic [RGB_W-1:0] rdata
);

  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read sees the table as it stood before this edge's write.
  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end

endmodule

// File: rtl/clut_window.sv
module clut_window
  import clut_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int RGB_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CH_W-1:0]  host_wdata,
  output logic [CH_W-1:0]  host_rdata,
  input  logic [CH_W-1:0]  pix_idx,
  output logic [RGB_W-1:0] pix_rgb,
  output logic [CH_W-1:0]  fmt_code,
  output logic             bank_one
);

  logic [CH_W-1:0]  addr_q;
  logic [1:0]       comp_q;
  logic             ctl_wr_evt;
  logic             commit_evt;
  logic [RGB_W-1:0] commit_rgb;
  logic [CH_W-1:0]  ctl_rd;

  clut_host_if #(.CH_W(CH_W)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .addr_q     (addr_q),
    .comp_q     (comp_q),
    .ctl_wr_evt (ctl_wr_evt),
    .commit_evt (commit_evt),
    .commit_rgb (commit_rgb)
  );

  clut_ctl_regs #(.CH_W(CH_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_evt),
    .idx      (addr_q),
    .wdata    (host_wdata),
    .rd_data  (ctl_rd),
    .fmt_q    (fmt_code),
    .bank_bit (bank_one)
  );

  clut_ram #(.CH_W(CH_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_evt),
    .waddr (addr_q),
    .wdata (commit_rgb),
    .raddr (pix_idx),
    .rdata (pix_rgb)
  );

  always_comb begin
    case (port_e'(host_sel))
      PORT_ADDR: host_rdata = addr_q;
      PORT_CTL:  host_rdata = ctl_rd;
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/clut_window_chk.sv
module clut_window_chk
  import clut_pkg::*;
#(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_wr,
  input logic [1:0]      host_sel,
  input logic [CH_W-1:0] host_rdata,
  input logic [CH_W-1:0] addr_q,
  input logic [1:0]      comp_q,
  input logic            commit_evt,
  input logic [CH_W-1:0] fmt_code,
  input logic            bank_one
);

  logic addr_wr;
  logic ctl_wr;
  assign addr_wr = host_wr && (host_sel == 2'd0);
  assign ctl_wr  = host_wr && (host_sel == 2'd1);

  assert_addr_clears_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> comp_q == 2'd0);

  assert_no_commit_after_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> !commit_evt);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(addr_q));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ($stable(fmt_code) && $stable(bank_one)));

  assert_unknown_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 2'd1 && !ctl_known(8'(addr_q))) |-> host_rdata == '0);

  assert_commit_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> comp_q == 2'd0);

  assert_comp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    comp_q != 2'd3);

  assert_idle_port_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel[1] |-> host_rdata == '0);

endmodule

bind clut_window clut_window_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_rdata (host_rdata),
  .addr_q     (addr_q),
  .comp_q     (comp_q),
  .commit_evt (commit_evt),
  .fmt_code   (fmt_code),
  .bank_one   (bank_one)
);

// File: tb/test_clut_window.sv
module test_clut_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] pix_rgb;
  logic [7:0]  fmt_code;
  logic        bank_one;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clut_window i_clut_window (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_idx(pix_idx),
    .pix_rgb(pix_rgb), .fmt_code(fmt_code), .bank_one(bank_one)
  );

  // ---------------- reference model ----------------
  int m_pal [256];
  bit m_known [256];
  int m_addr, m_comp, m_red, m_grn;
  int m_aux0, m_aux1, m_fmt, m_bank;
  int m_pix;
  bit m_pix_known;

  function automatic int model_ctl(input int idx);
    if (idx == 'h10) return m_aux0;
    if (idx == 'h11) return m_aux1;
    if (idx == 'h20) return m_fmt;
    if (idx == 'h21) return m_bank;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_comp = 0; m_red = 0; m_grn = 0;
      m_aux0 = 0; m_aux1 = 0; m_fmt = 'h10; m_bank = 1;
      m_pix = 0; m_pix_known = 1;
    end else begin
      m_pix_known = m_known[pix_idx];
      m_pix = m_pal[pix_idx];
      if (host_wr) begin
        case (host_sel)
          2'd0: begin m_addr = host_wdata; m_comp = 0; end
          2'd1: begin
            if (m_addr == 'h10) m_aux0 = host_wdata;
            else if (m_addr == 'h11) m_aux1 = host_wdata;
            else if (m_addr == 'h20) m_fmt = host_wdata;
            else if (m_addr == 'h21) m_bank = host_wdata;
          end
          2'd2: begin
            if (m_comp == 0) begin m_red = host_wdata; m_comp = 1; end
            else if (m_comp == 1) begin m_grn = host_wdata; m_comp = 2; end
            else begin
              m_pal[m_addr] = (m_red << 16) | (m_grn << 8) | host_wdata;
              m_known[m_addr] = 1;
              m_comp = 0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int exp_rd;
      case (host_sel)
        2'd0: exp_rd = m_addr;
        2'd1: exp_rd = model_ctl(m_addr);
        default: exp_rd = 0;
      endcase
      chk(host_sel == 2'd1 ? "R6/R8 host_rdata" :
          (host_sel == 2'd0 ? "R2 host_rdata" : "R10 host_rdata"),
          int'(host_rdata), exp_rd);
      chk("R7 fmt_code", int'(fmt_code), m_fmt & 'hff);
      chk("R7 bank_one", int'(bank_one), m_bank & 1);
      if (m_pix_known) chk("R5 pix_rgb", int'(pix_rgb), m_pix);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit wr, input int sel, input int data);
    @(negedge clk);
    host_wr = wr; host_sel = 2'(sel); host_wdata = 8'(data);
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int sel);
    cyc(0, sel, 0);
  endtask

  task automatic load_entry(input int idx, input int r, input int g, input int b);
    cyc(1, 0, idx);
    cyc(1, 2, r);
    cyc(1, 2, g);
    cyc(1, 2, b);
    idle(0);
  endtask

  task automatic rd_pix(input int idx, output int val);
    @(negedge clk);
    host_wr = 0; pix_idx = 8'(idx);
    @(posedge clk);
    #2;
    val = int'(pix_rgb);
  endtask

  task automatic ctl_write(input int idx, input int val);
    cyc(1, 0, idx);
    cyc(1, 1, val);
    idle(1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    for (int i = 0; i < 256; i++) begin m_known[i] = 0; m_pal[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset state
    idle(0); chk("R1 addr after reset", int'(host_rdata), 0);
    chk("R1 pix_rgb after reset", int'(pix_rgb), 0);
    chk("R1 fmt_code reset", int'(fmt_code), 'h10);
    chk("R1 bank_one reset", int'(bank_one), 1);
    cyc(1, 0, 'h10); idle(1); chk("R1 reg 0x10 reset", int'(host_rdata), 0);
    cyc(1, 0, 'h11); idle(1); chk("R1 reg 0x11 reset", int'(host_rdata), 0);

    // R2 address readback
    cyc(1, 0, 'h5c); idle(0); chk("R2 address readback", int'(host_rdata), 'h5c);

    // R3 entry load, address kept
    load_entry('h40, 'h12, 'h34, 'h56);
    chk("R3 address unchanged after load", int'(host_rdata), 'h40);
    rd_pix('h40, v); chk("R3 entry 0x40", v, 'h123456);
    load_entry('h41, 'hff, 'h00, 'h80);
    rd_pix('h41, v); chk("R3 entry 0x41", v, 'hff0080);
    // fourth byte starts new red on same entry
    cyc(1, 0, 'h42); cyc(1, 2, 1); cyc(1, 2, 2); cyc(1, 2, 3);
    cyc(1, 2, 'ha0); cyc(1, 2, 'hb0); cyc(1, 2, 'hc0);
    rd_pix('h42, v); chk("R3 second load same entry", v, 'ha0b0c0);

    // R9 neighbours untouched
    rd_pix('h40, v); chk("R9 entry 0x40 kept", v, 'h123456);
    rd_pix('h41, v); chk("R9 entry 0x41 kept", v, 'hff0080);

    // R4 partial load discarded
    cyc(1, 0, 'h40); cyc(1, 2, 'haa); cyc(1, 2, 'hbb);
    cyc(1, 0, 'h40); cyc(1, 2, 'h11);
    rd_pix('h40, v); chk("R4 partial discarded", v, 'h123456);
    cyc(1, 2, 'h22); cyc(1, 2, 'h33);
    rd_pix('h40, v); chk("R4 restart from red", v, 'h112233);

    // R5 read during commit returns old, then new
    cyc(1, 0, 'h41); cyc(1, 2, 'h01); cyc(1, 2, 'h02);
    @(negedge clk);
    pix_idx = 8'h41; host_wr = 1; host_sel = 2'd2; host_wdata = 8'h03;
    @(posedge clk); #2;
    chk("R5 old value on commit edge", int'(pix_rgb), 'hff0080);
    rd_pix('h41, v); chk("R5 new value next edge", v, 'h010203);

    // R6 / R7 control registers
    ctl_write('h20, 'h64);
    chk("R6 reg 0x20 readback", int'(host_rdata), 'h64);
    chk("R7 fmt_code", int'(fmt_code), 'h64);
    ctl_write('h21, 'h00);
    chk("R7 bank two selected", int'(bank_one), 0);
    ctl_write('h10, 'h5a); chk("R6 reg 0x10", int'(host_rdata), 'h5a);
    ctl_write('h11, 'hc3); chk("R6 reg 0x11", int'(host_rdata), 'hc3);

    // R8 unimplemented index
    ctl_write('h22, 'hee);
    chk("R8 unknown index reads zero", int'(host_rdata), 0);
    chk("R8 fmt_code unchanged", int'(fmt_code), 'h64);
    cyc(1, 0, 'h10); idle(1); chk("R8 reg 0x10 unchanged", int'(host_rdata), 'h5a);

    // R10 select 3 ignored
    cyc(1, 0, 'h43); cyc(1, 2, 'h77); cyc(1, 3, 'h99); cyc(1, 2, 'h88);
    idle(0); chk("R10 address kept", int'(host_rdata), 'h43);
    cyc(1, 2, 'h66);
    rd_pix('h43, v); chk("R10 component count kept", v, 'h778866);
    idle(2); chk("R10 palette port reads zero", int'(host_rdata), 0);

    // Random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      host_wr = ($urandom_range(0, 3) != 0);
      if (r < 15) host_sel = 2'd0;
      else if (r < 30) host_sel = 2'd1;
      else if (r < 92) host_sel = 2'd2;
      else host_sel = 2'd3;
      host_wdata = (host_sel == 2'd0 && r[0]) ? 8'($urandom_range('h10, 'h22))
                                              : 8'($urandom);
      pix_idx = (r < 50) ? 8'($urandom) : 8'(m_addr);
    end
    @(negedge clk) host_wr = 0;
    repeat (2) @(posedge clk);
    #6;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule